// File: doc/BRIEF.md
# Word-to-Stream Transmit Buffer

This block takes 32-bit words that a processor writes through a small register window. It queues them in a FIFO, then sends each word out on an AXI4-Stream master port as a series of narrower beats. The TDATA width is set at build time to 8, 16 or 32 bits. Each queued word carries an end-of-frame selector, written beforehand through a separate register. A zero selector sends the whole word with no frame end. A nonzero selector cuts the word short after its highest marked part and flags that beat with TLAST.

Software can read a full flag, an empty flag and the number of words waiting in the FIFO. It can set a level threshold. An interrupt output stays high while the waiting count is at or below that threshold, so a refill can be triggered when the queue runs low. An enable bit gates the stream. A self-clearing soft-reset bit empties the queue and drops any word that is partly sent.

Register map (write and read addresses share it): 0 = push data (write only); 1 = end-of-frame selector for the next push; 2 = control (bit 0 enable, bit 1 soft reset, reads back enable); 3 = threshold; 4 = status (bit 0 full, bit 1 empty); 5 = FIFO level.

Top module: `stream_tx_buffer`

## Requirements
- R1: After reset, TVALID is 0, the level reads 0, the status reads 2 (empty, not full), the threshold is 0, the enable bit is 0 and the interrupt is 1.
- R2: A write to address 0 while the FIFO is not full queues the word with the current selector, and the level read at address 5 goes up by one. The level counts only the words still waiting, not the word being sent.
- R3: A write to address 0 while the FIFO is full is dropped: the level does not change and the word never appears on the stream.
- R4: Status bit 0 reads 1 exactly when the level equals the FIFO depth (8 by default). Status bit 1 reads 1 when the level is 0.
- R5: The parts of a word go out least-significant first: beat k carries word bits [k*W+W-1 : k*W], where W is the TDATA width.
- R6: A word whose selector is 0 is sent as 32/W beats with TLAST low on all of them.
- R7: With a nonzero selector, the word is sent as beats 0 up to the index of the highest set selector bit, with TLAST high on the last beat only. Lower clear bits do not remove beats; for example, with W=8, selector 4'b0101 gives 3 beats.
- R8: While TVALID is high and TREADY is low, TVALID, TDATA and TLAST hold their values at the next clock.
- R9: While enable is 0, no new beat is presented. A beat already showing stays until it is accepted; TVALID then stays low until enable returns.
- R10: Writing control with bit 1 set empties the FIFO, drops TVALID and the word being sent, and clears the selector register. Enable takes the value of bit 0, and the threshold keeps its value.
- R11: The interrupt output equals (level <= threshold) at all times.
- R12: The selector register reads back what was written to it, and returns to 0 after a push that the FIFO accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | TDW | Stream beat data |
| m_tlast | output | 1 | Last beat of a frame |
| irq | output | 1 | High while level <= threshold |

## Verification
A wrong read or write pointer shows up at the first beat of the affected word, as a TDATA value that differs from the word pushed in that position. A miscounted level shows up at once on the level read, the full flag and the interrupt. A wrong beat index or selector decode shows up within one word as a missing or extra beat, or as TLAST landing on the wrong beat. This is caught when the next beat does not match the expected one. A beat that changes while stalled is caught on the first clock after the stall begins.

// File: rtl/stb_pkg.sv
package stb_pkg;
  // Number of beats a word needs: all parts for a zero selector,
  // otherwise up to and including the highest set selector bit.
  function automatic int unsigned beat_count(input logic [3:0] sel, input int unsigned parts);
    int unsigned n;
    n = parts;
    if (sel != 4'd0) begin
      for (int i = 0; i < 4; i++)
        if (sel[i]) n = i + 1;
    end
    return n;
  endfunction

  // Part k of a 32-bit word, for a part width w.
  function automatic logic [31:0] part_of(input logic [31:0] word, input int unsigned k,
                                          input int unsigned w);
    return word >> (k * w);
  endfunction
endpackage

// File: rtl/stb_fifo.sv
module stb_fifo #(
  parameter int W  = 33,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (level == (AW+1)'(DEPTH));
  assign empty = (level == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      level <= level + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n) level <= (AW+1)'(DEPTH));
endmodule

// File: rtl/stb_serializer.sv
module stb_serializer #(
  parameter int TDW = 8,
  parameter int SW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic           avail,
  input  logic [31:0]    in_word,
  input  logic [SW-1:0]  in_sel,
  output logic           take,
  output logic           m_tvalid,
  input  logic           m_tready,
  output logic [TDW-1:0] m_tdata,
  output logic           m_tlast
);
  localparam int IW = (SW > 1) ? $clog2(SW) : 1;

  logic          busy, vld;
  logic [31:0]   word;
  logic [SW-1:0] sel;
  logic [IW-1:0] idx;

  logic [IW-1:0] last_idx;
  logic          beat_fire, is_final, word_done;

  assign last_idx  = IW'(stb_pkg::beat_count(4'(sel), SW) - 1);
  assign beat_fire = vld & m_tready;
  assign is_final  = (idx == last_idx);
  assign word_done = beat_fire & is_final;
  assign take      = en & avail & !clr & (!busy | word_done);

  assign m_tvalid = vld;
  assign m_tdata  = TDW'(stb_pkg::part_of(word, 32'(idx), TDW));
  assign m_tlast  = (|sel) & is_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; vld <= 1'b0; idx <= '0; word <= '0; sel <= '0;
    end else if (clr) begin
      busy <= 1'b0; vld <= 1'b0; idx <= '0;
    end else if (take) begin
      busy <= 1'b1; vld <= 1'b1; idx <= '0; word <= in_word; sel <= in_sel;
    end else if (word_done) begin
      busy <= 1'b0; vld <= 1'b0;
    end else if (beat_fire) begin
      idx <= idx + 1'b1;
      vld <= en;
    end else if (busy && !vld && en) begin
      vld <= 1'b1;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && !clr) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
  p_tlast_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tlast) |-> (sel != '0));
  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !m_tvalid) |=> !m_tvalid);
  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= last_idx));
endmodule

// File: rtl/stream_tx_buffer.sv
module stream_tx_buffer #(
  parameter int TDW = 8,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_waddr,
  input  logic [31:0]    reg_wdata,
  input  logic [2:0]     reg_raddr,
  output logic [31:0]    reg_rdata,
  output logic           m_tvalid,
  input  logic           m_tready,
  output logic [TDW-1:0] m_tdata,
  output logic           m_tlast,
  output logic           irq
);
  localparam int SW = 32 / TDW;
  localparam int LW = AW + 1;
  localparam int FW = 32 + SW;

  logic          enable;
  logic [LW-1:0] thresh;
  logic [SW-1:0] sel_reg;

  logic          soft_rst, push_req, push_ok, pop;
  logic [FW-1:0] f_dout;
  logic [LW-1:0] level;
  logic          full, empty;

  assign soft_rst = reg_we && (reg_waddr == 3'd2) && reg_wdata[1];
  assign push_req = reg_we && (reg_waddr == 3'd0) && !soft_rst;
  assign push_ok  = push_req && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0; thresh <= '0; sel_reg <= '0;
    end else begin
      if (reg_we && reg_waddr == 3'd2) enable <= reg_wdata[0];
      if (reg_we && reg_waddr == 3'd3) thresh <= reg_wdata[LW-1:0];
      if (soft_rst || push_ok)                 sel_reg <= '0;
      else if (reg_we && reg_waddr == 3'd1)    sel_reg <= reg_wdata[SW-1:0];
    end
  end

  stb_fifo #(.W(FW), .AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .push(push_ok), .din({sel_reg, reg_wdata}),
    .pop(pop), .dout(f_dout),
    .level(level), .full(full), .empty(empty)
  );

  stb_serializer #(.TDW(TDW), .SW(SW)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .en(enable),
    .avail(!empty), .in_word(f_dout[31:0]), .in_sel(f_dout[FW-1:32]),
    .take(pop),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast)
  );

  assign irq = (level <= thresh);

  always_comb begin
    case (reg_raddr)
      3'd1:    reg_rdata = 32'(sel_reg);
      3'd2:    reg_rdata = 32'(enable);
      3'd3:    reg_rdata = 32'(thresh);
      3'd4:    reg_rdata = {30'd0, empty, full};
      3'd5:    reg_rdata = 32'(level);
      default: reg_rdata = 32'd0;
    endcase
  end

  p_full_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop) |=> (level == $past(level)));
  p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (level == '0 && !m_tvalid && sel_reg == '0));
  p_sel_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> (sel_reg == '0));
endmodule

// File: tb/sim_stream_tx_buffer.sv
module sim_stream_tx_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        m_tvalid, m_tready = 1'b0, m_tlast, irq;
  logic [7:0]  m_tdata;

  int checks = 0, errors = 0, hs_count = 0;
  int rdy_mode = 0;
  bit mon_on = 1'b0, prev_wait = 1'b0, done = 1'b0;
  logic [7:0]  prev_d;
  logic        prev_l;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0]  q[$];

  always #5 clk = ~clk;

  stream_tx_buffer #(.TDW(8), .AW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tlast(m_tlast), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_raddr = a; #1; v = reg_rdata;
  endtask

  // Driver: queues the expected beats of a word the FIFO should accept.
  task automatic expect_word(input logic [31:0] d, input logic [3:0] s);
    int n;
    n = s[3] ? 4 : s[2] ? 3 : s[1] ? 2 : s[0] ? 1 : 4;
    for (int i = 0; i < n; i++)
      q.push_back({(s != 0) && (i == n - 1), d[8*i +: 8]});
  endtask

  task automatic push(input logic [31:0] d, input logic [3:0] s, input bit accepted);
    if (s != 0) wr(3'd1, 32'(s));
    wr(3'd0, d);
    if (accepted) expect_word(d, s);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3000 && q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  // Monitor: drives TREADY, checks stall hold, compares accepted beats.
  always @(negedge clk) begin
    if (mon_on && prev_wait)
      chk(m_tvalid && m_tdata == prev_d && m_tlast == prev_l, "R8 hold",
          {m_tvalid, m_tlast, m_tdata}, {1'b1, prev_l, prev_d});
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? lfsr[0] : 1'b0;
    prev_wait = mon_on && m_tvalid && !m_tready;
    prev_d = m_tdata; prev_l = m_tlast;
    if (mon_on && m_tvalid && m_tready) begin
      hs_count++;
      if (q.size() == 0) chk(1'b0, "R3/R7 unexpected beat", {m_tlast, m_tdata}, 0);
      else begin
        logic [8:0] e;
        e = q.pop_front();
        chk({m_tlast, m_tdata} == e, "R5/R6/R7 beat", {m_tlast, m_tdata}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(m_tvalid == 0, "R1 tvalid", m_tvalid, 0);
    rd(3'd5, v); chk(v == 0, "R1 level", v, 0);
    rd(3'd4, v); chk(v == 2, "R1 status", v, 2);
    rd(3'd3, v); chk(v == 0, "R1 thresh", v, 0);
    rd(3'd2, v); chk(v == 0, "R1 enable", v, 0);
    chk(irq == 1, "R1 irq", irq, 1);

    mon_on = 1'b1; rdy_mode = 1;
    // Fill while disabled (R2, R4, R9)
    push(32'h11223344, 4'h0, 1);
    rd(3'd5, v); chk(v == 1, "R2 level after push", v, 1);
    push(32'h55667788, 4'h1, 1);
    push(32'h99AABBCC, 4'h2, 1);
    push(32'hDDEEFF00, 4'h4, 1);
    push(32'h01234567, 4'h8, 1);
    push(32'h89ABCDEF, 4'h5, 1);
    push(32'hCAFEF00D, 4'h0, 1);
    rd(3'd4, v); chk(v == 0, "R4 not full at 7", v, 0);
    push(32'hDEADBEEF, 4'h3, 1);
    rd(3'd5, v); chk(v == 8, "R2 level full", v, 8);
    rd(3'd4, v); chk(v == 1, "R4 full flag", v, 1);
    chk(m_tvalid == 0, "R9 no beat while disabled", m_tvalid, 0);
    // R11 threshold
    wr(3'd3, 7); #1 chk(irq == 0, "R11 irq level 8 > 7", irq, 0);
    wr(3'd3, 8); #1 chk(irq == 1, "R11 irq level 8 <= 8", irq, 1);
    wr(3'd3, 3);
    // R3 dropped write
    push(32'hBADBAD00, 4'h0, 0);
    rd(3'd5, v); chk(v == 8, "R3 level unchanged", v, 8);
    // Enable with random ready
    rdy_mode = 2;
    wr(3'd2, 1);
    drain("R5 drain");
    rd(3'd5, v); chk(v == 0, "R2 level empty", v, 0);
    rd(3'd4, v); chk(v == 2, "R4 empty flag", v, 2);
    chk(irq == 1, "R11 irq at level 0", irq, 1);

    // R12 selector register
    wr(3'd1, 6); rd(3'd1, v); chk(v == 6, "R12 readback", v, 6);
    wr(3'd0, 32'h0BADF00D); expect_word(32'h0BADF00D, 4'h6);
    rd(3'd1, v); chk(v == 0, "R12 cleared after push", v, 0);
    drain("R7 drain sel 6");

    // R9 mid-word disable
    rdy_mode = 0;
    push(32'hA1B2C3D4, 4'h0, 1);
    repeat (3) @(negedge clk);
    chk(m_tvalid == 1, "R9 beat shown", m_tvalid, 1);
    wr(3'd2, 0);
    h0 = hs_count;
    rdy_mode = 1;
    repeat (6) @(negedge clk);
    chk(hs_count - h0 == 1, "R9 one beat then stop", hs_count - h0, 1);
    chk(m_tvalid == 0, "R9 tvalid low", m_tvalid, 0);
    wr(3'd2, 1);
    drain("R9 resume");
    chk(hs_count - h0 == 4, "R6 four beats", hs_count - h0, 4);

    // R10 soft reset
    rdy_mode = 0;
    push(32'h10203040, 4'h0, 1);
    push(32'h50607080, 4'h0, 1);
    push(32'h90A0B0C0, 4'h0, 1);
    wr(3'd1, 4);
    repeat (2) @(negedge clk);
    rd(3'd5, v); chk(v == 2, "R2 level excludes word in flight", v, 2);
    wr(3'd3, 1); #1 chk(irq == 0, "R11 irq level 2 > 1", irq, 0);
    mon_on = 1'b0;
    wr(3'd2, 32'h3);
    q.delete();
    chk(m_tvalid == 0, "R10 tvalid dropped", m_tvalid, 0);
    rd(3'd5, v); chk(v == 0, "R10 level cleared", v, 0);
    rd(3'd3, v); chk(v == 1, "R10 thresh kept", v, 1);
    rd(3'd1, v); chk(v == 0, "R10 selector cleared", v, 0);
    rd(3'd2, v); chk(v == 1, "R10 enable from bit0", v, 1);
    @(negedge clk);
    mon_on = 1'b1; rdy_mode = 1;
    push(32'h000000E7, 4'h1, 1);
    drain("R10 after soft reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule